// File: doc/BRIEF.md
# Random number peripheral

A register-mapped random number source on a plain 32-bit read/write bus. Software picks one of two generation modes: a true-random mode, where each output word is the XOR of the enabled stand-in entropy sources, or a pseudo-random mode, where a single LFSR supplies the words. The pseudo-random state can be reseeded from the current true-random state through a self-clearing strobe.

Generation fills a buffer of eight 32-bit words. The block then raises data-ready. Software pulls the words one at a time from the data register and clears data-ready with a write-one-to-clear store to the status register, which allows the next batch to start. Health-fail, data-ready and error flags can drive one interrupt line. Four seeded LFSRs stand in for the physical oscillators. An input pin injects a health-test failure.

Top module: `rng_periph`

## Requirements
- R1: Register offsets are control 0x00, mode 0x04, status 0x08, data 0x0C and reseed 0x40. Control bit 0 enables generation, bits 7:4 enable sources 0..3, bit 16 enables the data-ready interrupt, bit 17 enables the error interrupt and bit 24 is the global interrupt enable. Control reads back only these bits and all other bits read 0. Mode bit 0 reads back as written. Read data appears on `rdata_o` on the clock edge that samples `rd_en_i`, and is 0 on cycles without a read.
- R2: Each source is a 32-bit Galois LFSR with next = (s >> 1) ^ (s[0] ? 32'h80200003 : 0). Source i is seeded with 32'h12345678 + i*32'h9E3779B9. All sources advance once per generated word, and in true-random mode (mode bit 0 = 0) the word is the XOR of the advanced states of the enabled sources.
- R3: In pseudo-random mode (mode bit 0 = 1), a separate LFSR with the same step function and seed 32'hC0FFEE01 advances once per word and supplies the word. Writing 1 to reseed bit 0 replaces its state with state XOR (XOR of all four source states), or with the seed if that result is zero. The reseed is applied before any further batch starts, and the reseed register reads 0.
- R4: A batch writes eight words, after which status bit 1 (data-ready) sets. No batch starts while data-ready is set. Once data-ready is cleared with generation still enabled, a new batch begins.
- R5: Each data read while data-ready is set returns the next buffered word in order. A data read with no word left, or with data-ready clear, returns 0 and sets status bit 3 (error).
- R6: Writing 1 to status bits 0, 1 or 3 clears them. A flag being set in the same cycle wins over the clear.
- R7: In true-random mode with generation enabled, data-ready clear and no source enabled, no batch starts and the error flag sets.
- R8: A high `health_fail_i` sets status bit 0.
- R9: `irq_o` is high exactly when the global enable is set and either data-ready is set with its enable on, or error or health-fail is set with the error enable on.
- R10: After reset, control, mode and status read 0 and `irq_o` is low.
- R11: With control bit 0 clear, no batch is generated and the sources do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe for one cycle |
| rdata_o | output | 32 | Registered read data |
| health_fail_i | input | 1 | Injected health-test failure |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en_i` and `rd_en_i` are never high in the same cycle, and that a reseed strobe is not repeated while a previous one is still pending. The bench issues one bus transaction at a time with an idle cycle between them, and writes reseed only while the generator is idle. It changes the mode and the source enables only between batches, so every batch runs with a fixed configuration and the arithmetic model of the LFSRs stays in step with the design.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int WORD_W = 32;

  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_MODE   = 'h04;
  localparam int OFF_STAT   = 'h08;
  localparam int OFF_DATA   = 'h0C;
  localparam int OFF_RESEED = 'h40;

  localparam int CTRL_GEN     = 0;
  localparam int CTRL_OSC_LSB = 4;
  localparam int CTRL_DIE     = 16;
  localparam int CTRL_EIE     = 17;
  localparam int CTRL_GIE     = 24;

  localparam int ST_HF   = 0;
  localparam int ST_DRDY = 1;
  localparam int ST_ERR  = 3;

  localparam logic [WORD_W-1:0] LFSR_POLY     = 32'h8020_0003;
  localparam logic [WORD_W-1:0] OSC_SEED_BASE = 32'h1234_5678;
  localparam logic [WORD_W-1:0] OSC_SEED_STEP = 32'h9E37_79B9;
  localparam logic [WORD_W-1:0] PRNG_SEED     = 32'hC0FF_EE01;

  typedef enum logic [0:0] {GEN_IDLE = 1'b0, GEN_FILL = 1'b1} gen_state_e;

  function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_POLY : '0);
  endfunction

  function automatic logic [WORD_W-1:0] osc_seed(input int idx);
    return OSC_SEED_BASE + OSC_SEED_STEP * WORD_W'(idx);
  endfunction
endpackage

// File: rtl/rng_src_bank.sv
module rng_src_bank
  import rng_pkg::*;
#(
  parameter int N_OSC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [N_OSC-1:0]  en_i,
  output logic [WORD_W-1:0] sel_next_o,
  output logic [WORD_W-1:0] all_q_o
);
  logic [N_OSC-1:0][WORD_W-1:0] st_q;
  logic [N_OSC-1:0][WORD_W-1:0] st_next;

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    assign st_next[g] = lfsr_next(st_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_OSC; i++) st_q[i] <= osc_seed(i);
    end else if (step_i) begin
      st_q <= st_next;
    end
  end

  always_comb begin
    sel_next_o = '0;
    all_q_o    = '0;
    for (int i = 0; i < N_OSC; i++) begin
      if (en_i[i]) sel_next_o = sel_next_o ^ st_next[i];
      all_q_o = all_q_o ^ st_q[i];
    end
  end
endmodule

// File: rtl/rng_prng.sv
module rng_prng
  import rng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              reseed_i,
  input  logic [WORD_W-1:0] mix_i,
  output logic [WORD_W-1:0] next_o
);
  logic [WORD_W-1:0] st_q;
  logic [WORD_W-1:0] mixed;

  assign next_o = lfsr_next(st_q);
  assign mixed  = st_q ^ mix_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       st_q <= PRNG_SEED;
    else if (reseed_i) st_q <= (mixed == '0) ? PRNG_SEED : mixed;
    else if (step_i)   st_q <= next_o;
  end
endmodule

// File: rtl/rng_batch_buf.sv
module rng_batch_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [W-1:0]     rdata_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (wr_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/rng_periph.sv
module rng_periph
  import rng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_OSC  = 4,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              health_fail_i,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic             gen_en_q, die_q, eie_q, gie_q, mode_q;
  logic [N_OSC-1:0] osc_en_q;
  logic             hf_q, drdy_q, err_q, reseed_pend_q;
  gen_state_e       state_q;
  logic [IDX_W-1:0] fill_idx_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [WORD_W-1:0] rdata_q;

  logic wr_ctrl, wr_mode, wr_stat, wr_reseed, rd_data;
  assign wr_ctrl   = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_mode   = wr_en_i && (addr_i == ADDR_W'(OFF_MODE));
  assign wr_stat   = wr_en_i && (addr_i == ADDR_W'(OFF_STAT));
  assign wr_reseed = wr_en_i && (addr_i == ADDR_W'(OFF_RESEED));
  assign rd_data   = rd_en_i && (addr_i == ADDR_W'(OFF_DATA));

  logic stall, start, filling, abort, step, last, reseed_apply, avail, err_set;
  assign stall        = gen_en_q && !mode_q && (osc_en_q == '0);
  assign filling      = (state_q == GEN_FILL);
  assign reseed_apply = reseed_pend_q && !filling;
  assign start        = !filling && gen_en_q && !drdy_q && !reseed_pend_q && !stall;
  assign abort        = filling && (!gen_en_q || stall);
  assign step         = filling && !abort;
  assign last         = step && (fill_idx_q == IDX_W'(DEPTH - 1));
  assign avail        = drdy_q && (rd_ptr_q != PTR_W'(DEPTH));
  assign err_set      = (rd_data && !avail) || (stall && !drdy_q);

  logic [WORD_W-1:0] osc_word, osc_all, prng_word, fill_word, buf_word;

  rng_src_bank #(.N_OSC(N_OSC)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .en_i       (osc_en_q),
    .sel_next_o (osc_word),
    .all_q_o    (osc_all)
  );

  rng_prng u_prng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step && mode_q),
    .reseed_i (reseed_apply),
    .mix_i    (osc_all),
    .next_o   (prng_word)
  );

  assign fill_word = mode_q ? prng_word : osc_word;

  rng_batch_buf #(.DEPTH(DEPTH), .W(WORD_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (step),
    .widx_i  (fill_idx_q),
    .wdata_i (fill_word),
    .ridx_i  (rd_ptr_q[IDX_W-1:0]),
    .rdata_o (buf_word)
  );

  logic [WORD_W-1:0] ctrl_rd, stat_rd, rd_mux;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_GEN]               = gen_en_q;
    ctrl_rd[CTRL_OSC_LSB +: N_OSC]  = osc_en_q;
    ctrl_rd[CTRL_DIE]               = die_q;
    ctrl_rd[CTRL_EIE]               = eie_q;
    ctrl_rd[CTRL_GIE]               = gie_q;
    stat_rd = '0;
    stat_rd[ST_HF]   = hf_q;
    stat_rd[ST_DRDY] = drdy_q;
    stat_rd[ST_ERR]  = err_q;
    rd_mux = '0;
    if (addr_i == ADDR_W'(OFF_CTRL))      rd_mux = ctrl_rd;
    else if (addr_i == ADDR_W'(OFF_MODE)) rd_mux = {{(WORD_W-1){1'b0}}, mode_q};
    else if (addr_i == ADDR_W'(OFF_STAT)) rd_mux = stat_rd;
    else if (addr_i == ADDR_W'(OFF_DATA)) rd_mux = avail ? buf_word : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_en_q      <= 1'b0;
      osc_en_q      <= '0;
      die_q         <= 1'b0;
      eie_q         <= 1'b0;
      gie_q         <= 1'b0;
      mode_q        <= 1'b0;
      hf_q          <= 1'b0;
      drdy_q        <= 1'b0;
      err_q         <= 1'b0;
      reseed_pend_q <= 1'b0;
      state_q       <= GEN_IDLE;
      fill_idx_q    <= '0;
      rd_ptr_q      <= '0;
      rdata_q       <= '0;
    end else begin
      if (wr_ctrl) begin
        gen_en_q <= wdata_i[CTRL_GEN];
        osc_en_q <= wdata_i[CTRL_OSC_LSB +: N_OSC];
        die_q    <= wdata_i[CTRL_DIE];
        eie_q    <= wdata_i[CTRL_EIE];
        gie_q    <= wdata_i[CTRL_GIE];
      end
      if (wr_mode) mode_q <= wdata_i[0];
      reseed_pend_q <= (wr_reseed && wdata_i[0]) || (reseed_pend_q && !reseed_apply);
      // set wins over write-one-to-clear
      hf_q   <= health_fail_i || (hf_q && !(wr_stat && wdata_i[ST_HF]));
      drdy_q <= last || (drdy_q && !(wr_stat && wdata_i[ST_DRDY]));
      err_q  <= err_set || (err_q && !(wr_stat && wdata_i[ST_ERR]));
      unique case (state_q)
        GEN_IDLE: if (start) begin
          state_q    <= GEN_FILL;
          fill_idx_q <= '0;
        end
        GEN_FILL: begin
          if (abort || last) state_q <= GEN_IDLE;
          if (step) fill_idx_q <= fill_idx_q + 1'b1;
        end
        default: state_q <= GEN_IDLE;
      endcase
      if (last)                  rd_ptr_q <= '0;
      else if (rd_data && avail) rd_ptr_q <= rd_ptr_q + 1'b1;
      rdata_q <= rd_en_i ? rd_mux : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = gie_q && ((drdy_q && die_q) || ((err_q || hf_q) && eie_q));
endmodule

// File: rtl/rng_periph_chk.sv
module rng_periph_chk
  import rng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic              rd_en_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              health_fail_i,
  input logic              irq_o,
  input logic              gie_q,
  input logic              drdy_q,
  input logic              err_q,
  input logic              hf_q,
  input logic              reseed_pend_q,
  input logic [0:0]        state_q,
  input logic [PTR_W-1:0]  rd_ptr_q
);
  logic clr_drdy;
  assign clr_drdy = wr_en_i && (addr_i == ADDR_W'(OFF_STAT)) && wdata_i[ST_DRDY];

  a_r9_irq_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_q);

  a_r4_drdy_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drdy_q && !clr_drdy) |=> drdy_q);

  a_r4_no_fill_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_q |-> (state_q == GEN_IDLE));

  a_r5_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == ADDR_W'(OFF_DATA)) && !drdy_q) |=> (rdata_o == '0 && err_q));

  a_r5_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ptr_q <= PTR_W'(DEPTH));

  a_r3_reseed_before_batch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == GEN_FILL) |-> !$past(reseed_pend_q));

  a_r8_hf_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    health_fail_i |=> hf_q);

  a_r1_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));
endmodule

bind rng_periph rng_periph_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_en_i       (wr_en_i),
  .wdata_i       (wdata_i),
  .rd_en_i       (rd_en_i),
  .rdata_o       (rdata_o),
  .health_fail_i (health_fail_i),
  .irq_o         (irq_o),
  .gie_q         (gie_q),
  .drdy_q        (drdy_q),
  .err_q         (err_q),
  .hf_q          (hf_q),
  .reseed_pend_q (reseed_pend_q),
  .state_q       (state_q),
  .rd_ptr_q      (rd_ptr_q)
);

// File: tb/tb_rng_periph.sv
module tb_rng_periph;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, hfail = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_periph dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .health_fail_i(hfail), .irq_o(irq)
  );

  logic [31:0] m_osc [4];
  logic [31:0] m_prng;

  function automatic logic [31:0] stepf(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); d = rdata; rd_en = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    logic [31:0] s;
    s = '0;
    for (int k = 0; k < 40 && !s[1]; k++) rd(8'h08, s);
    check(req, {31'b0, s[1]}, 32'h1);
  endtask

  task automatic check_batch(input string req, input bit prng, input logic [3:0] mask);
    logic [31:0] got, exp;
    for (int k = 0; k < 8; k++) begin
      exp = '0;
      for (int i = 0; i < 4; i++) begin
        m_osc[i] = stepf(m_osc[i]);
        if (mask[i]) exp ^= m_osc[i];
      end
      if (prng) begin
        m_prng = stepf(m_prng);
        exp = m_prng;
      end
      rd(8'h0C, got);
      check(req, got, exp);
    end
  endtask

  task automatic model_reseed();
    logic [31:0] mx;
    mx = m_prng ^ m_osc[0] ^ m_osc[1] ^ m_osc[2] ^ m_osc[3];
    m_prng = (mx == 0) ? 32'hC0FF_EE01 : mx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 4; i++) m_osc[i] = 32'h1234_5678 + 32'h9E37_79B9 * i;
    m_prng = 32'hC0FF_EE01;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    check("R10 irq", {31'b0, irq}, 0);
    rd(8'h00, v); check("R10 ctrl", v, 0);
    rd(8'h04, v); check("R10 mode", v, 0);
    rd(8'h08, v); check("R10 status", v, 0);

    // R5 data read with nothing buffered
    rd(8'h0C, v); check("R5 empty read", v, 0);
    rd(8'h08, v); check("R5 err flag", v, 32'h8);
    wr(8'h08, 32'h8);
    rd(8'h08, v); check("R6 clear err", v, 0);

    // R1 readback masks (generation left off)
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h00, v); check("R1 ctrl mask", v, 32'h0103_00F0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R1 mode set", v, 1);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R1 mode clr", v, 0);
    rd(8'h40, v); check("R3 reseed reads 0", v, 0);

    // R11 enables on, generation off
    wr(8'h00, 32'h0000_00F0);
    repeat (20) @(negedge clk);
    rd(8'h08, v); check("R11 no batch", v, 0);

    // R7 stall with no source
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk);
    rd(8'h08, v); check("R7 stall err", v, 32'h8);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'hB);
    rd(8'h08, v); check("R6 clear after stall", v, 0);

    // R2/R4/R5 sweep over every source mask
    wr(8'h00, 32'h1 | (32'h1 << 4));
    for (int m = 1; m < 16; m++) begin
      wait_ready("R4 ready");
      repeat (20) @(negedge clk);   // R4 no refill while ready
      check_batch("R2 trng word", 1'b0, 4'(m));
      rd(8'h0C, v); check("R5 overread", v, 0);
      rd(8'h08, v); check("R5 overread err", v, 32'hA);
      if (m < 15) wr(8'h00, 32'h1 | (32'(m + 1) << 4));
      else        wr(8'h00, 32'h0);
      wr(8'h08, 32'hB);             // R4 clearing ready restarts
    end
    rd(8'h08, v); check("R6 status clear", v, 0);

    // R3 pseudo-random with reseed
    wr(8'h04, 32'h1);
    wr(8'h40, 32'h1);
    model_reseed();
    wr(8'h00, 32'h1);
    wait_ready("R3 ready");
    check_batch("R3 prng reseeded", 1'b1, 4'h0);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'hB);
    wr(8'h00, 32'h1);
    wait_ready("R3 ready2");
    check_batch("R3 prng continue", 1'b1, 4'h0);
    rd(8'h08, v); check("R4 only ready", v, 32'h2);

    // R9 data-ready interrupt sweep
    for (int c = 0; c < 8; c++) begin
      wr(8'h00, (32'(c & 1) << 24) | (32'((c >> 1) & 1) << 16) | (32'((c >> 2) & 1) << 17));
      check("R9 irq drdy", {31'b0, irq}, 32'((c & 1) & ((c >> 1) & 1)));
    end
    wr(8'h00, 32'h0);
    wr(8'h08, 32'hB);
    rd(8'h08, v); check("R6 clear ready", v, 0);

    // R8 health fail, R9 error interrupt sweep
    @(negedge clk); hfail = 1'b1;
    @(negedge clk); hfail = 1'b0;
    rd(8'h08, v); check("R8 hf flag", v, 32'h1);
    for (int c = 0; c < 8; c++) begin
      wr(8'h00, (32'(c & 1) << 24) | (32'((c >> 1) & 1) << 16) | (32'((c >> 2) & 1) << 17));
      check("R9 irq hf", {31'b0, irq}, 32'((c & 1) & ((c >> 2) & 1)));
    end

    // R6 set wins over clear
    @(negedge clk); hfail = 1'b1;
    wr(8'h08, 32'h1);
    rd(8'h08, v); check("R6 set wins", v, 32'h1);
    hfail = 1'b0;
    wr(8'h08, 32'h1);
    rd(8'h08, v); check("R6 hf cleared", v, 0);
    check("R9 irq off", {31'b0, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule